// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-clock synchronous static RAM whose bus can alternate between reads and writes on every cycle with no idle turnaround slot. Commands and addresses are captured on the rising clock edge. Read data leaves a registered output two edges later. Write data is taken on the bus two edges after its command, so both directions use the same bus slot and mixed traffic runs at full rate. An internal address pipeline holds each write's address and byte enables until its data arrives.

A load cycle (`adv_ld` low) captures a fresh address and starts a read, a write or a deselect. An advance cycle (`adv_ld` high) steps a 2-bit burst counter and repeats the running operation at the next address within an aligned group of four words. Linear or interleaved burst order is picked with `ilv_mode`. Holding `cke_n` high freezes the whole block. The output enable gates a valid flag that stands in for tri-stating the data pins.

Top module: `zt_sram`

## Requirements
- R1: After `rst_n` is released, `dout_vld` is low until a read completes.
- R2: A read loaded at edge k puts the addressed word on `dout` after edge k+2, with `dout_vld` high while `oe_n` is low.
- R3: A write loaded at edge k takes its data from `din` at edge k+2. Lane i (bits 8i+7..8i) is written only when `bw_n[i]` is low. A write never raises `dout_vld`.
- R4: Reads and writes may alternate on consecutive edges with no idle cycle, and a read issued after a write to the same address returns the newly written data.
- R5: A load cycle with `cs_n` high is a deselect. It touches no memory, and `dout_vld` is low in its output slot.
- R6: With `adv_ld` high, the previous operation repeats with the burst counter plus one. In linear order the low two address bits are (loaded low bits + count) mod 4 and the upper bits are kept. Byte enables come from `bw_n` of each beat.
- R7: With `ilv_mode` high, the low two address bits of a burst beat are the loaded low bits XOR the count.
- R8: On an edge with `cke_n` high, all inputs are ignored and every register, memory word and output holds. Operation then resumes where it stopped.
- R9: While `oe_n` is high, `dout_vld` is low, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cke_n | input | 1 | Active-low clock enable; high freezes the block |
| cs_n | input | 1 | Active-low select, sampled on load cycles |
| adv_ld | input | 1 | 0 loads a new address and operation, 1 advances the burst |
| we_n | input | 1 | Active-low write, sampled on load cycles |
| bw_n | input | DATA_W/LANE_W | Active-low byte-lane write enables |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data, taken two edges after its command |
| oe_n | input | 1 | Active-low output enable |
| ilv_mode | input | 1 | 1 selects interleaved burst order, 0 linear |
| dout | output | DATA_W | Registered read data |
| dout_vld | output | 1 | Read data is driven (low models high impedance) |

## Verification
A slip in the two-stage command pipeline shows up as data on the wrong edge or from the wrong word, two edges after the disturbed command. It shows up as `dout_vld` wrong in the slot of a write or deselect, or as write data landing at a neighbouring address and surfacing at the next read of it. A wrong burst counter shows on the second beat, where the word of an unexpected address appears. A clock-enable leak corrupts the very next output sample, or leaves a stray write visible at the next read of that address.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke_n,
  input  logic                       cs_n,
  input  logic                       adv_ld,
  input  logic                       we_n,
  input  logic [DATA_W/LANE_W-1:0]   bw_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          din,
  input  logic                       oe_n,
  input  logic                       ilv_mode,
  output logic [DATA_W-1:0]          dout,
  output logic                       dout_vld
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {OP_IDLE, OP_RD, OP_WR} op_t;

  logic [DATA_W-1:0] mem [DEPTH];

  op_t              op_q, op1_q, op2_q;
  logic [ADDR_W-1:0] base_q, a1_q, a2_q;
  logic [1:0]        cnt_q;
  logic [LANES-1:0]  bw1_q, bw2_q;
  logic              vld_q;
  logic [DATA_W-1:0] dout_q;

  wire               load    = !adv_ld;
  wire [1:0]         cnt_nx  = load ? 2'd0 : cnt_q + 2'd1;
  wire [ADDR_W-1:0]  base_nx = load ? addr : base_q;
  wire [1:0]         low_nx  = ilv_mode ? (base_nx[1:0] ^ cnt_nx) : (base_nx[1:0] + cnt_nx);
  wire [ADDR_W-1:0]  ea_nx   = {base_nx[ADDR_W-1:2], low_nx};
  op_t               op_nx;

  always_comb begin
    if (!load)     op_nx = op_q;
    else if (cs_n) op_nx = OP_IDLE;
    else if (we_n) op_nx = OP_RD;
    else           op_nx = OP_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      op1_q  <= OP_IDLE;
      op2_q  <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      a1_q   <= '0;
      a2_q   <= '0;
      bw1_q  <= '1;
      bw2_q  <= '1;
      vld_q  <= 1'b0;
    end else if (!cke_n) begin
      op_q   <= op_nx;
      base_q <= base_nx;
      cnt_q  <= cnt_nx;
      op1_q  <= op_nx;
      a1_q   <= ea_nx;
      bw1_q  <= bw_n;
      op2_q  <= op1_q;
      a2_q   <= a1_q;
      bw2_q  <= bw1_q;
      vld_q  <= (op2_q == OP_RD);
    end
  end

  always_ff @(posedge clk) begin
    if (!cke_n && rst_n) begin
      if (op2_q == OP_WR) begin
        for (int i = 0; i < LANES; i++)
          if (!bw2_q[i]) mem[a2_q][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
      end
      if (op2_q == OP_RD) dout_q <= mem[a2_q];
    end
  end

  assign dout     = dout_q;
  assign dout_vld = vld_q & ~oe_n;
endmodule

module zt_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_n,
  input logic              cs_n,
  input logic              adv_ld,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld
);
  a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_vld);

  a_r8_freeze_dout: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dout));

  a_r5_desel_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && cs_n) ##1 !cke_n ##1 !cke_n |=> !dout_vld);

  a_r3_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !cs_n && !we_n) ##1 !cke_n ##1 !cke_n |=> !dout_vld);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !cs_n && we_n) ##1 !cke_n ##1 !cke_n |=> (oe_n || dout_vld));
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_n(cs_n), .adv_ld(adv_ld),
  .we_n(we_n), .oe_n(oe_n), .dout(dout), .dout_vld(dout_vld)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_n = 1'b1, cs_n = 1'b1, adv_ld = 1'b0, we_n = 1'b1;
  logic [3:0]  bw_n = 4'hf;
  logic [7:0]  addr = '0;
  logic [31:0] din = '0;
  logic        oe_n = 1'b0, ilv_mode = 1'b0;
  logic [31:0] dout;
  logic        dout_vld;

  int checks = 0, errors = 0;

  zt_sram i_zt_sram (.*);

  always #2 clk = ~clk;

  logic [31:0] mm [256];
  logic [1:0]  m_op, p1_op, p2_op;
  logic [7:0]  m_base, p1_a, p2_a;
  logic [1:0]  m_cnt;
  logic [3:0]  p1_bw, p2_bw;
  logic [31:0] ex_dat;
  logic        ex_vld;

  task automatic check(input string tag);
    checks++;
    if (dout_vld !== (ex_vld && !oe_n)) begin
      errors++;
      $display("FAIL %s dout_vld=%b exp=%b", tag, dout_vld, ex_vld && !oe_n);
    end else if (ex_vld && !oe_n && dout !== ex_dat) begin
      errors++;
      $display("FAIL %s dout=%h exp=%h", tag, dout, ex_dat);
    end
  endtask

  task automatic step(input logic ck, cs, adv, we, input logic [3:0] bw,
                      input logic [7:0] a, input logic [31:0] d, input string tag);
    logic [1:0] nop;
    logic [7:0] na;
    logic [1:0] lo;
    @(negedge clk);
    cke_n = ck; cs_n = cs; adv_ld = adv; we_n = we; bw_n = bw; addr = a; din = d;
    if (!ck) begin
      if (!adv) begin
        nop = cs ? 2'd0 : (we ? 2'd1 : 2'd2);
        m_base = a; m_cnt = 2'd0;
      end else begin
        nop = m_op; m_cnt = m_cnt + 2'd1;
      end
      m_op = nop;
      lo = ilv_mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      na = {m_base[7:2], lo};
      ex_vld = 1'b0;
      if (p2_op == 2'd2) begin
        for (int i = 0; i < 4; i++) if (!p2_bw[i]) mm[p2_a][i*8 +: 8] = d[i*8 +: 8];
      end else if (p2_op == 2'd1) begin
        ex_dat = mm[p2_a]; ex_vld = 1'b1;
      end
      p2_op = p1_op; p2_a = p1_a; p2_bw = p1_bw;
      p1_op = nop;   p1_a = na;   p1_bw = bw;
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string t);
    step(0, 0, 0, 0, 4'h0, a, d, t);
  endtask
  task automatic rd(input logic [7:0] a, input logic [31:0] d, input string t);
    step(0, 0, 0, 1, 4'hf, a, d, t);
  endtask
  task automatic nop(input logic [31:0] d, input string t);
    step(0, 1, 0, 1, 4'hf, 8'h00, d, t);
  endtask

  task automatic t_reset;
    nop(0, "R1 reset idle");
    nop(0, "R1 reset idle");
    nop(0, "R1 reset idle");
  endtask

  task automatic t_single;
    wr(8'h10, 0, "R3 write cmd");
    nop(0, "R3 gap");
    nop(32'hDEADBEEF, "R3 write data");
    rd(8'h10, 0, "R2 read cmd");
    nop(0, "R2 wait");
    nop(0, "R2 read data");
    nop(0, "R2 after");
  endtask

  task automatic t_bytes;
    step(0, 0, 0, 0, 4'b1010, 8'h10, 0, "R3 partial cmd");
    nop(0, "R3 gap");
    nop(32'h11223344, "R3 partial data");
    rd(8'h10, 0, "R3 lanes read");
    nop(0, "R3 wait");
    nop(0, "R3 lanes 0,2 new, 1,3 kept");
  endtask

  task automatic t_pingpong;
    wr(8'h20, 0, "R4 w20");
    rd(8'h10, 0, "R4 r10");
    wr(8'h21, 32'hA0A0A020, "R4 w21");
    rd(8'h20, 0, "R4 r20");
    wr(8'h22, 32'hA0A0A021, "R4 w22");
    rd(8'h21, 0, "R4 r21");
    wr(8'h20, 32'hA0A0A022, "R4 w20 again");
    rd(8'h20, 0, "R4 r20 new");
    nop(32'h5555AAAA, "R4 drain");
    nop(0, "R4 drain");
    nop(0, "R4 drain");
  endtask

  task automatic t_desel;
    rd(8'h20, 0, "R5 read before");
    step(0, 1, 0, 0, 4'h0, 8'h20, 0, "R5 deselect with we low");
    nop(0, "R5 slot read");
    nop(32'hFFFFFFFF, "R5 slot deselect");
    rd(8'h20, 0, "R5 untouched cmd");
    nop(0, "R5 wait");
    nop(0, "R5 untouched data");
  endtask

  task automatic t_burst(input logic mode, input logic [7:0] a, input string t);
    ilv_mode = mode;
    for (int i = 0; i < 4; i++) wr(8'h30 + 8'(i), (i >= 2) ? 32'hB0B0_0030 + 32'(i) - 2 : 0, t);
    nop(32'hB0B0_0032, t);
    nop(32'hB0B0_0033, t);
    step(0, 0, 0, 0, 4'h0, a, 0, t);
    step(0, 0, 1, 1, 4'h0, 8'hff, 0, t);
    step(0, 0, 1, 1, 4'h0, 8'hff, 32'hC0C0_0000, t);
    step(0, 0, 1, 1, 4'h0, 8'hff, 32'hC0C0_0001, t);
    nop(32'hC0C0_0002, t);
    nop(32'hC0C0_0003, t);
    step(0, 0, 0, 1, 4'hf, a, 0, t);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 4'hf, 8'hff, 0, t);
    for (int i = 0; i < 4; i++) nop(0, t);
    ilv_mode = 1'b0;
  endtask

  task automatic t_stall;
    rd(8'h10, 0, "R8 read cmd");
    step(1, 0, 0, 0, 4'h0, 8'h10, 32'h0BAD0BAD, "R8 stall garbage write");
    nop(0, "R8 resume");
    step(1, 0, 1, 0, 4'h0, 8'h11, 32'h0BAD0BAD, "R8 stall holds");
    step(1, 1, 0, 1, 4'hf, 8'h00, 0, "R8 stall holds");
    nop(0, "R8 read data after stall");
    nop(0, "R8 after");
    rd(8'h10, 0, "R8 no stray write");
    step(1, 0, 0, 0, 4'h0, 8'h10, 32'h0BAD0BAD, "R8 stall mid");
    nop(0, "R8 mid");
    nop(0, "R8 value intact");
  endtask

  task automatic t_oe;
    rd(8'h20, 0, "R9 cmd");
    nop(0, "R9 wait");
    oe_n = 1'b1;
    nop(0, "R9 oe high hides data");
    @(negedge clk); oe_n = 1'b0; #0.5;
    checks++;
    if (dout_vld !== 1'b1) begin
      errors++; $display("FAIL R9 oe low dout_vld=%b exp=1", dout_vld);
    end
    nop(0, "R9 after");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = '0;
    m_op = 0; p1_op = 0; p2_op = 0; m_base = 0; m_cnt = 0;
    p1_a = 0; p2_a = 0; p1_bw = 4'hf; p2_bw = 4'hf; ex_vld = 0; ex_dat = 0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (dout_vld !== 1'b0) begin
      errors++; $display("FAIL R1 in reset dout_vld=%b exp=0", dout_vld);
    end
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_single();
    t_bytes();
    t_pingpong();
    t_desel();
    t_burst(1'b0, 8'h32, "R6 linear burst");
    t_burst(1'b1, 8'h31, "R7 interleaved burst");
    t_stall();
    t_oe();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule